// File: doc/BRIEF.md
# Seven-to-one LVDS pixel serializer (single link)

This block turns one parallel RGB pixel per pixel period, together with horizontal sync, vertical sync and data-enable, into up to four serial data lanes of seven bits each plus a matching clock-lane pattern. It runs entirely on a bit-rate clock at seven times the pixel rate. An internal phase counter divides each pixel period into seven bit slots.

A pixel word is captured at the boundary between pixel periods and shifted out over the next seven slots. A 3-bit mapping selector chooses between three bit placements. The 18-bit placement carries six bits per colour on three lanes. The 24-bit standard placement adds the two top colour bits on a fourth lane. The 24-bit alternate placement puts the six upper colour bits on the first three lanes and the two lowest bits on the fourth lane.

Outputs are single-ended bit streams. The upstream video source holds its pixel inputs for at least the slot before each boundary. It uses `wordStart` to know which slot opens a period.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: Each lane emits its seven-bit word in index order, bit 0 in slot 0 through bit 6 in slot 6. `wordStart` is high in slot 0 and low in the other six slots. Inputs are sampled at the clock edge that ends slot 6.
- R2: In every mapping, lane 2 carries hsync in bit 4, vsync in bit 5 and data-enable in bit 6.
- R3: In the 18-bit mapping (mode 3'b000) and the 24-bit standard mapping (mode 3'b010), the colour bits are placed as follows:
  - lane 0 bits 0-5 carry red[0..5], and bit 6 carries green[0];
  - lane 1 bits 0-4 carry green[1..5], and bits 5-6 carry blue[0..1];
  - lane 2 bits 0-3 carry blue[2..5].
- R4: In the 24-bit standard mapping, lane 3 bits 0-5 carry red[6], red[7], green[6], green[7], blue[6] and blue[7].
- R5: In the 24-bit alternate mapping (mode 3'b001), colour bits 2-7 take the lane 0-2 positions that R3 gives to bits 0-5. Lane 3 bits 0-5 carry red[0], red[1], green[0], green[1], blue[0] and blue[1].
- R6: In the 18-bit mapping, and for every unassigned mode code (3'b011 to 3'b111), lane 3 is held at 0 and lanes 0-2 follow R3.
- R7: The clock lane is high in slots 5, 6, 0 and 1 and low in slots 2, 3 and 4. It rises two slots before slot 0.
- R8: Lane 3 bit 6 is always 0.
- R9: A change of mapping mode or pixel inputs during slots 0-5 has no effect on the word being shifted out. The new value applies only from the next boundary.
- R10: During reset all data lanes are 0, the clock lane is 1 and `wordStart` is 0. The first word is captured at the first clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit-rate clock, seven times the pixel rate |
| rstN | input | 1 | Active-low synchronous reset |
| mapMode | input | 3 | Bit-placement selector |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| den | input | 1 | Data enable |
| laneOut | output | 4 | Serial data lanes, index = lane number |
| clkLane | output | 1 | Serial clock-lane pattern |
| wordStart | output | 1 | High in slot 0 of each pixel period |

## Verification
The assertions are checked on every cycle. They cover the phase counter range, the slots where the clock lane rises and falls, and the sync and enable bits in lane 2 against the inputs sampled at the last boundary. They also check that lane 3 stays silent in the 18-bit and unassigned modes and in slot 6.

Only the bench scenarios can show the colour bit placements of the three mappings, where exact field values are compared. The same holds for the immunity of an in-flight word to mode and input changes, and for the reset values.

// File: rtl/lvds_ser_pkg.sv
`timescale 1ns/1ps
package lvds_ser_pkg;
  localparam int SLOTS = 7;
  localparam int NUM_LANES = 4;
  localparam int COLOR_W = 8;

  typedef enum logic [2:0] {
    MAP_18   = 3'b000,
    MAP_ALT24 = 3'b001,
    MAP_STD24 = 3'b010
  } mapSel_e;

  typedef struct packed {
    logic load;
    logic shift;
  } serStrobe_t;
endpackage

// File: rtl/lvds_ser_ctrl.sv
`timescale 1ns/1ps
module lvds_ser_ctrl
  import lvds_ser_pkg::*;
#(
  parameter int N_SLOTS = SLOTS,
  parameter int CLK_RISE_SLOT = 5,
  parameter int CLK_HIGH_SLOTS = 4,
  localparam int PW = $clog2(N_SLOTS)
) (
  input  logic          bitClk,
  input  logic          rstN,
  output serStrobe_t    strobe,
  output logic [PW-1:0] phase,
  output logic          clkLane,
  output logic          wordStart
);
  localparam logic [PW-1:0] LAST = PW'(N_SLOTS - 1);

  function automatic logic clkHigh(input int p);
    return ((p + N_SLOTS - CLK_RISE_SLOT) % N_SLOTS) < CLK_HIGH_SLOTS;
  endfunction

  logic [PW-1:0] nextPhase;

  assign nextPhase = (phase == LAST) ? '0 : phase + 1'b1;
  assign strobe.load = (phase == LAST);
  assign strobe.shift = (phase != LAST);
  assign wordStart = rstN && (phase == '0);

  always_ff @(posedge bitClk) begin
    if (!rstN) begin
      phase <= LAST;
      clkLane <= clkHigh(N_SLOTS - 1);
    end else begin
      phase <= nextPhase;
      clkLane <= clkHigh(int'(nextPhase));
    end
  end
endmodule

// File: rtl/lvds_ser_datapath.sv
`timescale 1ns/1ps
module lvds_ser_datapath
  import lvds_ser_pkg::*;
#(
  parameter int N_LANES = NUM_LANES,
  parameter int N_SLOTS = SLOTS,
  parameter int CW = COLOR_W
) (
  input  logic               bitClk,
  input  logic               rstN,
  input  serStrobe_t         strobe,
  input  logic [2:0]         mapMode,
  input  logic [CW-1:0]      red,
  input  logic [CW-1:0]      green,
  input  logic [CW-1:0]      blue,
  input  logic               hsync,
  input  logic               vsync,
  input  logic               den,
  output logic [N_LANES-1:0] laneOut
);
  logic [N_LANES-1:0][N_SLOTS-1:0] word;
  logic [5:0] rHi, gHi, bHi;
  logic [1:0] rLo, gLo, bLo;
  logic lane3On;

  always_comb begin
    lane3On = 1'b1;
    case (mapMode)
      MAP_ALT24: begin
        rHi = red[7:2];   gHi = green[7:2];   bHi = blue[7:2];
        rLo = red[1:0];   gLo = green[1:0];   bLo = blue[1:0];
      end
      MAP_STD24: begin
        rHi = red[5:0];   gHi = green[5:0];   bHi = blue[5:0];
        rLo = red[7:6];   gLo = green[7:6];   bLo = blue[7:6];
      end
      default: begin
        rHi = red[5:0];   gHi = green[5:0];   bHi = blue[5:0];
        rLo = '0;         gLo = '0;           bLo = '0;
        lane3On = 1'b0;
      end
    endcase
    word = '0;
    word[0] = {gHi[0], rHi};
    word[1] = {bHi[1:0], gHi[5:1]};
    word[2] = {den, vsync, hsync, bHi[5:2]};
    if (lane3On) word[3] = {1'b0, bLo, gLo, rLo};
  end

  genvar ln;
  generate
    for (ln = 0; ln < N_LANES; ln++) begin : g_lane
      logic [N_SLOTS-1:0] shReg;
      always_ff @(posedge bitClk) begin
        if (!rstN) shReg <= '0;
        else if (strobe.load) shReg <= word[ln];
        else if (strobe.shift) shReg <= shReg >> 1;
      end
      assign laneOut[ln] = shReg[0];
    end
  endgenerate
endmodule

// File: rtl/lvds_pixel_serializer.sv
`timescale 1ns/1ps
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
#(
  parameter int N_LANES = NUM_LANES,
  parameter int N_SLOTS = SLOTS,
  parameter int CW = COLOR_W
) (
  input  logic               bitClk,
  input  logic               rstN,
  input  logic [2:0]         mapMode,
  input  logic [CW-1:0]      red,
  input  logic [CW-1:0]      green,
  input  logic [CW-1:0]      blue,
  input  logic               hsync,
  input  logic               vsync,
  input  logic               den,
  output logic [N_LANES-1:0] laneOut,
  output logic               clkLane,
  output logic               wordStart
);
  localparam int PW = $clog2(N_SLOTS);

  serStrobe_t strobe;
  logic [PW-1:0] phase;

  lvds_ser_ctrl #(.N_SLOTS(N_SLOTS)) ctrl_i (
    .bitClk(bitClk), .rstN(rstN), .strobe(strobe), .phase(phase),
    .clkLane(clkLane), .wordStart(wordStart)
  );

  lvds_ser_datapath #(.N_LANES(N_LANES), .N_SLOTS(N_SLOTS), .CW(CW)) dp_i (
    .bitClk(bitClk), .rstN(rstN), .strobe(strobe), .mapMode(mapMode),
    .red(red), .green(green), .blue(blue), .hsync(hsync), .vsync(vsync),
    .den(den), .laneOut(laneOut)
  );
endmodule

// File: rtl/lvds_ser_chk.sv
`timescale 1ns/1ps
module lvds_ser_chk #(
  parameter int PW = 3
) (
  input logic          bitClk,
  input logic          rstN,
  input logic [PW-1:0] phase,
  input logic          load,
  input logic [2:0]    mapMode,
  input logic          hsync,
  input logic          vsync,
  input logic          den,
  input logic [3:0]    laneOut,
  input logic          clkLane,
  input logic          wordStart
);
  logic [2:0] heldMode;
  always_ff @(posedge bitClk) begin
    if (!rstN) heldMode <= 3'b000;
    else if (load) heldMode <= mapMode;
  end

  // R1
  phase_range_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    phase < 3'd7);
  // R1
  word_start_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    wordStart |=> !wordStart);
  // R7
  clk_rise_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    $rose(clkLane) |-> phase == 3'd5);
  // R7
  clk_fall_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    $fell(clkLane) |-> phase == 3'd2);
  // R2
  hsync_slot_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    (phase == 3'd4) |-> laneOut[2] == $past(hsync, 5));
  // R2
  vsync_slot_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    (phase == 3'd5) |-> laneOut[2] == $past(vsync, 6));
  // R2
  den_slot_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    (phase == 3'd6) |-> laneOut[2] == $past(den, 7));
  // R6
  lane3_off_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    (heldMode != 3'b001 && heldMode != 3'b010) |-> !laneOut[3]);
  // R8
  lane3_pad_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    (phase == 3'd6) |-> !laneOut[3]);
endmodule

bind lvds_pixel_serializer lvds_ser_chk #(.PW(PW)) chk_i (
  .bitClk(bitClk), .rstN(rstN), .phase(phase), .load(strobe.load),
  .mapMode(mapMode), .hsync(hsync), .vsync(vsync), .den(den),
  .laneOut(laneOut), .clkLane(clkLane), .wordStart(wordStart)
);

// File: tb/lvds_pixel_serializer_tb.sv
`timescale 1ns/1ps
module lvds_pixel_serializer_tb_top;
  logic bitClk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] mapMode = 3'b000;
  logic [7:0] red = '0, green = '0, blue = '0;
  logic hsync = 1'b0, vsync = 1'b0, den = 1'b0;
  logic [3:0] laneOut;
  logic clkLane, wordStart;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 bitClk = ~bitClk;

  lvds_pixel_serializer dut_i (
    .bitClk(bitClk), .rstN(rstN), .mapMode(mapMode), .red(red), .green(green),
    .blue(blue), .hsync(hsync), .vsync(vsync), .den(den),
    .laneOut(laneOut), .clkLane(clkLane), .wordStart(wordStart)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected lane words, lane n in bits [7n +: 7]
  function automatic logic [27:0] expWord(input logic [2:0] m, input logic [7:0] r,
      input logic [7:0] g, input logic [7:0] b, input logic h, input logic v, input logic e);
    logic [5:0] r6, g6, b6;
    logic [6:0] l0, l1, l2, l3;
    int sh;
    sh = (m == 3'b001) ? 2 : 0;
    r6 = 6'(r >> sh); g6 = 6'(g >> sh); b6 = 6'(b >> sh);
    for (int i = 0; i < 6; i++) l0[i] = r6[i];
    l0[6] = g6[0];
    for (int i = 0; i < 5; i++) l1[i] = g6[i+1];
    l1[5] = b6[0]; l1[6] = b6[1];
    for (int i = 0; i < 4; i++) l2[i] = b6[i+2];
    l2[4] = h; l2[5] = v; l2[6] = e;
    if (m == 3'b010) l3 = {1'b0, b[7], b[6], g[7], g[6], r[7], r[6]};
    else if (m == 3'b001) l3 = {1'b0, b[1], b[0], g[1], g[0], r[1], r[0]};
    else l3 = '0;
    return {l3, l2, l1, l0};
  endfunction

  // One pixel period; optional change of mode/inputs in slot 3 (R9)
  task automatic sendPixel(input string tag, input logic [2:0] m, input logic [7:0] r,
      input logic [7:0] g, input logic [7:0] b, input logic h, input logic v,
      input logic e, input bit midChange);
    logic [27:0] exp, act;
    logic [6:0] clkAct;
    @(negedge bitClk);
    while (!wordStart) @(negedge bitClk);
    mapMode = m; red = r; green = g; blue = b; hsync = h; vsync = v; den = e;
    exp = expWord(m, r, g, b, h, v, e);
    repeat (7) @(negedge bitClk);
    check({tag, " R1 wordStart"}, int'(wordStart), 1);
    for (int k = 0; k < 7; k++) begin
      for (int ln = 0; ln < 4; ln++) act[ln*7 + k] = laneOut[ln];
      clkAct[k] = clkLane;
      if (midChange && k == 3) begin
        mapMode = ~m; red = ~r; green = ~g; blue = ~b; hsync = ~h; vsync = ~v; den = ~e;
      end
      if (k < 6) @(negedge bitClk);
    end
    check({tag, " R3/R5 lane0"}, int'(act[6:0]), int'(exp[6:0]));
    check({tag, " R2/R3 lane1"}, int'(act[13:7]), int'(exp[13:7]));
    check({tag, " R2 lane2"}, int'(act[20:14]), int'(exp[20:14]));
    check({tag, " R4/R6/R8 lane3"}, int'(act[27:21]), int'(exp[27:21]));
    check({tag, " R7 clock"}, int'(clkAct), int'(7'b1100011));
  endtask

  task automatic testReset();
    repeat (3) @(negedge bitClk);
    check("R10 lanes in reset", int'(laneOut), 0);
    check("R10 clkLane in reset", int'(clkLane), 1);
    check("R10 wordStart in reset", int'(wordStart), 0);
    rstN = 1'b1;
    @(negedge bitClk);
    check("R10 first word slot0", int'(wordStart), 1);
  endtask

  task automatic testModes();
    sendPixel("18bit R6", 3'b000, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0);
    sendPixel("std24 R4", 3'b010, 8'hA5, 8'h3C, 8'hC3, 1'b1, 1'b0, 1'b1, 1'b0);
    sendPixel("alt24 R5", 3'b001, 8'hA5, 8'h3C, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b0);
    sendPixel("alt24b R5", 3'b001, 8'h81, 8'h42, 8'h7E, 1'b1, 1'b0, 1'b0, 1'b0);
    sendPixel("unassigned R6", 3'b110, 8'hC7, 8'hE1, 8'h9B, 1'b0, 1'b0, 1'b1, 1'b0);
    sendPixel("walk R1", 3'b010, 8'h01, 8'h80, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testMidChange();
    sendPixel("midchange R9", 3'b010, 8'h5A, 8'h96, 8'h0F, 1'b1, 1'b0, 1'b1, 1'b1);
    sendPixel("after R9", 3'b001, 8'hF0, 8'h33, 8'hCC, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    testReset();
    testModes();
    testMidChange();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge bitClk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule